// File: doc/BRIEF.md
# Miss Status Handling Register File

This block sits beside the tag and data arrays of a non-blocking cache and keeps track of every block miss still in flight. A cache miss is presented on the allocate port. It carries the block address, a load or store flag, an access size, a byte offset inside the block, a destination tag and, for stores, the store data. If a miss to the same block is already pending, the access joins that entry and no second memory request goes out. If no such miss is pending, a free entry is claimed and a fetch is raised on the memory request port. When neither is possible, `alloc_ready` stays low and the requester must hold.

Subblocks come back from the next level one at a time, in any order, tagged with the entry index. Each one is written into the entry's own storage. Every access waiting on that subblock then becomes serviceable. One access is serviced per cycle. A pending store merges its bytes into the stored subblock. A pending load gets its bytes on the forward port. Once every subblock has arrived and every waiting access has been serviced, the entry writes the block out on the fill port, one subblock per cycle, and then frees itself. An allocation may also be flagged as a prefetch. A prefetch fetches the block without any waiting access, and the flag travels with the fill.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is valid. `mem_req_valid`, `fwd_valid` and `fill_valid` are low, and a miss to any block is accepted.
- R2: A miss to a block with no pending entry claims a free entry. That entry raises exactly one request, with `mem_req_addr` equal to the block address and `mem_req_id` equal to the entry index. The entry stays reserved until it is released after its fill.
- R3: A miss to a block that already has a pending entry joins that entry. No further memory request is made for the block.
- R4: `alloc_ready` is low in three cases. The first is a miss to a new block while all NENT entries are in use. The second is a demand access to a pending block whose NSLOT access slots have all been used since that entry was claimed; slots are not reused before the entry retires. The third is any access to a pending block whose subblocks have all arrived and whose accesses have all been serviced.
- R5: A load returns the addressed bytes of its subblock, shifted down to bit 0 and zero-extended. `alloc_size` 0, 1 and 2 mean 1, 2 and 4 bytes. `alloc_off` bits [3:2] select the subblock and bits [1:0] select the byte. Accesses are size-aligned and stay within one subblock.
- R6: Stores to a pending block take effect in the order they were allocated. A load sees exactly the stores allocated to the same block before it, on top of the returned data.
- R7: At most one access is serviced per cycle. The lowest entry index is taken first, then allocation order within the entry. Every load is forwarded exactly once, with its own tag.
- R8: A load that joins an entry whose needed subblock has already arrived is forwarded without waiting for the rest of the block.
- R9: An entry fills only after all of its subblocks have arrived and all of its accesses have been serviced. It emits subblocks 0 to NSUB-1 in increasing order. The data is the returned data with all stores merged in. The entry is freed with its last fill.
- R10: A prefetch allocation takes no access slot and still fetches the block. `fill_pf` is high on its fills unless a demand access joined the entry. A prefetch to an already pending block has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Miss presented |
| alloc_ready | output | 1 | Miss accepted this cycle; low means stall |
| alloc_addr | input | ADDRW | Block address |
| alloc_pf | input | 1 | Allocation is a prefetch |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_size | input | 2 | log2 of access bytes |
| alloc_off | input | log2(NSUB)+log2(SUBW/8) | Byte offset in block |
| alloc_tag | input | TAGW | Destination register or store-buffer index |
| alloc_wdata | input | SUBW | Store data, low bytes used |
| mem_req_valid | output | 1 | Block fetch request |
| mem_req_ready | input | 1 | Next level takes the request |
| mem_req_addr | output | ADDRW | Block address to fetch |
| mem_req_id | output | log2(NENT) | Entry index to return with data |
| ret_valid | input | 1 | Subblock returned |
| ret_id | input | log2(NENT) | Entry index of returned subblock |
| ret_sub | input | log2(NSUB) | Subblock index |
| ret_data | input | SUBW | Subblock data |
| fwd_valid | output | 1 | Load data forwarded |
| fwd_tag | output | TAGW | Tag of forwarded load |
| fwd_data | output | SUBW | Load data, zero-extended |
| fill_valid | output | 1 | Subblock written to cache |
| fill_addr | output | ADDRW | Block address of fill |
| fill_sub | output | log2(NSUB) | Subblock index of fill |
| fill_data | output | SUBW | Subblock data with stores merged |
| fill_pf | output | 1 | Filled block came from a prefetch only |

## Verification
The in-design assertions watch three properties on every cycle: no block address is held by two entries at once, an entry never raises a second memory request, and fills of one block step through subblock indices in order. They also check that an entry is released only in a cycle that followed its final fill with all subblocks present. Other behaviours depend on a history of several cycles, and only the bench's reference model can show them. Store-to-load ordering within a block, exact forwarded bytes for each size and offset, and fill contents after merged stores fall in this group. So do the stall cases for full entry pools and exhausted slots, and the handling of the prefetch flag.

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int NENT  = 4,
  parameter int NSLOT = 4,
  parameter int NSUB  = 4,
  parameter int SUBW  = 32,
  parameter int ADDRW = 26,
  parameter int TAGW  = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     alloc_valid,
  output logic                                     alloc_ready,
  input  logic [ADDRW-1:0]                         alloc_addr,
  input  logic                                     alloc_pf,
  input  logic                                     alloc_store,
  input  logic [1:0]                               alloc_size,
  input  logic [$clog2(NSUB)+$clog2(SUBW/8)-1:0]   alloc_off,
  input  logic [TAGW-1:0]                          alloc_tag,
  input  logic [SUBW-1:0]                          alloc_wdata,
  output logic                                     mem_req_valid,
  input  logic                                     mem_req_ready,
  output logic [ADDRW-1:0]                         mem_req_addr,
  output logic [$clog2(NENT)-1:0]                  mem_req_id,
  input  logic                                     ret_valid,
  input  logic [$clog2(NENT)-1:0]                  ret_id,
  input  logic [$clog2(NSUB)-1:0]                  ret_sub,
  input  logic [SUBW-1:0]                          ret_data,
  output logic                                     fwd_valid,
  output logic [TAGW-1:0]                          fwd_tag,
  output logic [SUBW-1:0]                          fwd_data,
  output logic                                     fill_valid,
  output logic [ADDRW-1:0]                         fill_addr,
  output logic [$clog2(NSUB)-1:0]                  fill_sub,
  output logic [SUBW-1:0]                          fill_data,
  output logic                                     fill_pf
);
  localparam int EW   = $clog2(NENT);
  localparam int SW   = $clog2(NSLOT);
  localparam int BW   = $clog2(NSUB);
  localparam int YW   = $clog2(SUBW/8);
  localparam int OFFW = BW + YW;
  localparam int PW   = $clog2(NSLOT+1);
  localparam int NBY  = SUBW/8;

  logic [NENT-1:0]  e_val, e_iss, e_pf;
  logic [ADDRW-1:0] e_addr [NENT];
  logic [NSUB-1:0]  e_arr  [NENT];
  logic [PW-1:0]    e_ptr  [NENT];
  logic [BW-1:0]    e_fcnt [NENT];
  logic [SUBW-1:0]  e_dat  [NENT][NSUB];
  logic [NSLOT-1:0] s_val  [NENT];
  logic             s_st   [NENT][NSLOT];
  logic [1:0]       s_sz   [NENT][NSLOT];
  logic [OFFW-1:0]  s_off  [NENT][NSLOT];
  logic [TAGW-1:0]  s_tag  [NENT][NSLOT];
  logic [SUBW-1:0]  s_wd   [NENT][NSLOT];

  logic [NENT-1:0] hit, cmpl;
  logic mhit, mfree, rq_v, fl_v, pk_v, acc;
  logic [EW-1:0] mi, fi, rq_e, fl_e, pk_e, te;
  logic [SW-1:0] pk_s, ts;

  always_comb begin
    hit = '0; cmpl = '0; mhit = 1'b0; mfree = 1'b0; rq_v = 1'b0; fl_v = 1'b0; pk_v = 1'b0;
    mi = '0; fi = '0; rq_e = '0; fl_e = '0; pk_e = '0; pk_s = '0;
    for (int e = NENT-1; e >= 0; e--) begin
      hit[e]  = e_val[e] && (e_addr[e] == alloc_addr);
      cmpl[e] = e_val[e] && (&e_arr[e]) && !(|s_val[e]);
      if (hit[e])                begin mhit = 1'b1;  mi = EW'(e);   end
      if (!e_val[e])             begin mfree = 1'b1; fi = EW'(e);   end
      if (e_val[e] && !e_iss[e]) begin rq_v = 1'b1;  rq_e = EW'(e); end
      if (cmpl[e])               begin fl_v = 1'b1;  fl_e = EW'(e); end
      for (int s = NSLOT-1; s >= 0; s--)
        if (s_val[e][s] && e_arr[e][s_off[e][s][OFFW-1:YW]]) begin
          pk_v = 1'b1; pk_e = EW'(e); pk_s = SW'(s);
        end
    end
  end

  assign alloc_ready = mhit ? (!cmpl[mi] && (alloc_pf || e_ptr[mi] != PW'(NSLOT))) : mfree;
  assign acc = alloc_valid && alloc_ready;
  assign te  = mhit ? mi : fi;
  assign ts  = mhit ? e_ptr[mi][SW-1:0] : '0;

  assign mem_req_valid = rq_v;
  assign mem_req_addr  = e_addr[rq_e];
  assign mem_req_id    = rq_e;

  logic [BW-1:0]   pk_sub;
  logic [YW-1:0]   pk_by;
  logic [SUBW-1:0] pk_word, ld_mask, st_word;
  int rel;
  assign pk_sub  = s_off[pk_e][pk_s][OFFW-1:YW];
  assign pk_by   = s_off[pk_e][pk_s][YW-1:0];
  assign pk_word = e_dat[pk_e][pk_sub];

  always_comb begin
    ld_mask = '0;
    st_word = pk_word;
    rel = 0;
    for (int b = 0; b < NBY; b++) begin
      rel = b - int'(pk_by);
      if (b < (1 << s_sz[pk_e][pk_s])) ld_mask[8*b +: 8] = 8'hff;
      if (rel >= 0 && rel < (1 << s_sz[pk_e][pk_s]))
        st_word[8*b +: 8] = s_wd[pk_e][pk_s][8*rel +: 8];
    end
  end

  assign fwd_valid = pk_v && !s_st[pk_e][pk_s];
  assign fwd_tag   = s_tag[pk_e][pk_s];
  assign fwd_data  = (pk_word >> {pk_by, 3'b000}) & ld_mask;

  assign fill_valid = fl_v;
  assign fill_addr  = e_addr[fl_e];
  assign fill_sub   = e_fcnt[fl_e];
  assign fill_data  = e_dat[fl_e][e_fcnt[fl_e]];
  assign fill_pf    = e_pf[fl_e];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_val <= '0; e_iss <= '0; e_pf <= '0;
      for (int e = 0; e < NENT; e++) begin
        s_val[e] <= '0; e_arr[e] <= '0; e_ptr[e] <= '0; e_fcnt[e] <= '0;
      end
    end else begin
      if (mem_req_valid && mem_req_ready) e_iss[rq_e] <= 1'b1;
      if (ret_valid) e_arr[ret_id][ret_sub] <= 1'b1;
      if (pk_v) s_val[pk_e][pk_s] <= 1'b0;
      if (fl_v) begin
        e_fcnt[fl_e] <= e_fcnt[fl_e] + 1'b1;
        if (e_fcnt[fl_e] == BW'(NSUB-1)) e_val[fl_e] <= 1'b0;
      end
      if (acc && mhit && !alloc_pf) begin
        s_val[mi][ts] <= 1'b1;
        e_ptr[mi]     <= e_ptr[mi] + PW'(1);
        e_pf[mi]      <= 1'b0;
      end else if (acc && !mhit) begin
        e_val[fi]  <= 1'b1;
        e_iss[fi]  <= 1'b0;
        e_pf[fi]   <= alloc_pf;
        e_arr[fi]  <= '0;
        e_fcnt[fi] <= '0;
        e_ptr[fi]  <= alloc_pf ? PW'(0) : PW'(1);
        s_val[fi]  <= alloc_pf ? '0 : NSLOT'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc && !mhit) e_addr[fi] <= alloc_addr;
    if (ret_valid) e_dat[ret_id][ret_sub] <= ret_data;
    if (pk_v && s_st[pk_e][pk_s]) e_dat[pk_e][pk_sub] <= st_word;
    if (acc && !alloc_pf) begin
      s_st[te][ts]  <= alloc_store;
      s_sz[te][ts]  <= alloc_size;
      s_off[te][ts] <= alloc_off;
      s_tag[te][ts] <= alloc_tag;
      s_wd[te][ts]  <= alloc_wdata;
    end
  end

  AST_UNIQUE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R3
  AST_REQ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !(mem_req_valid && mem_req_id == $past(mem_req_id))); // R2
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid || fill_addr != $past(fill_addr) || fill_sub == $past(fill_sub) + 1'b1); // R9
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> e_val[ret_id] && e_iss[ret_id] && !e_arr[ret_id][ret_sub]); // R2

  for (genvar g = 0; g < NENT; g++) begin : g_free
    AST_FREE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(e_val[g]) |-> $past(fill_valid && fl_e == EW'(g) && (&e_arr[g]))); // R9
  end
endmodule

// File: tb/test_mshr_file.sv
module test_mshr_file;
  localparam int NENT = 4, NSLOT = 4, NSUB = 4, SUBW = 32, ADDRW = 26, TAGW = 8;
  localparam int NBLK = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid, alloc_ready, alloc_pf, alloc_store;
  logic [ADDRW-1:0] alloc_addr;
  logic [1:0] alloc_size;
  logic [3:0] alloc_off;
  logic [TAGW-1:0] alloc_tag;
  logic [SUBW-1:0] alloc_wdata;
  logic mem_req_valid, mem_req_ready;
  logic [ADDRW-1:0] mem_req_addr;
  logic [1:0] mem_req_id;
  logic ret_valid;
  logic [1:0] ret_id, ret_sub;
  logic [SUBW-1:0] ret_data;
  logic fwd_valid;
  logic [TAGW-1:0] fwd_tag;
  logic [SUBW-1:0] fwd_data;
  logic fill_valid, fill_pf;
  logic [ADDRW-1:0] fill_addr;
  logic [1:0] fill_sub;
  logic [SUBW-1:0] fill_data;

  mshr_file #(.NENT(NENT), .NSLOT(NSLOT), .NSUB(NSUB), .SUBW(SUBW), .ADDRW(ADDRW), .TAGW(TAGW)) i_mshr_file (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_addr(alloc_addr), .alloc_pf(alloc_pf),
    .alloc_store(alloc_store), .alloc_size(alloc_size), .alloc_off(alloc_off), .alloc_tag(alloc_tag),
    .alloc_wdata(alloc_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .mem_req_id(mem_req_id),
    .ret_valid(ret_valid), .ret_id(ret_id), .ret_sub(ret_sub), .ret_data(ret_data),
    .fwd_valid(fwd_valid), .fwd_tag(fwd_tag), .fwd_data(fwd_data),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_sub(fill_sub), .fill_data(fill_data), .fill_pf(fill_pf));

  always #5 clk = ~clk;

  int vec = 0, bad = 0, cyc = 0;
  bit act_k[NBLK], reqd_k[NBLK], pf_k[NBLK];
  int rid_k[NBLK], nacc_k[NBLK], nfill_k[NBLK], pend_k[NBLK];
  logic [3:0] sent_k[NBLK];
  logic [31:0] img[NBLK][4];
  int last_seq[NBLK][4];
  int id_k[NENT];
  bit id_busy[NENT];
  logic [31:0] exp_d[256];
  int exp_kk[256], exp_sb[256], exp_seq[256];
  bit live[256], early[256];
  int nout = 0, nreq = 0, seq = 0, r8_cnt = 0;
  logic [7:0] tagc = 8'd0;

  bit d_av, d_pf, d_st, mem_rdy_en, ret_en;
  int d_k, d_sz, d_sub, d_by;
  logic [31:0] d_wd;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDRW-1:0] blkaddr(int k);
    return ADDRW'(k * 1237 + 77);
  endfunction

  function automatic logic [31:0] memword(int k, int s);
    return (32'(k * 4 + s + 1) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] ldval(logic [31:0] w, int by, int sz);
    logic [31:0] m;
    m = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFFFFFF;
    return (w >> (8 * by)) & m;
  endfunction

  function automatic logic [31:0] stmerge(logic [31:0] w, logic [31:0] d, int by, int sz);
    for (int b = 0; b < 4; b++)
      if (b >= by && b < by + (1 << sz)) w[8*b +: 8] = d[8*(b-by) +: 8];
    return w;
  endfunction

  function automatic int findk(logic [ADDRW-1:0] a);
    for (int k = 0; k < NBLK; k++) if (blkaddr(k) == a) return k;
    return -1;
  endfunction

  task automatic step();
    int k;
    bit m, known, er;
    @(negedge clk);
    alloc_valid = d_av; alloc_addr = blkaddr(d_k); alloc_pf = d_pf; alloc_store = d_st;
    alloc_size = 2'(d_sz); alloc_off = 4'(d_sub * 4 + d_by); alloc_tag = tagc; alloc_wdata = d_wd;
    mem_req_ready = mem_rdy_en && ($urandom % 10 < 7);
    ret_valid = 1'b0; ret_id = '0; ret_sub = '0; ret_data = '0;
    if (ret_en && ($urandom % 2 == 1)) begin
      int id = $urandom % NENT;
      if (id_busy[id] && sent_k[id_k[id]] != 4'hF) begin
        int s = $urandom % 4;
        while (sent_k[id_k[id]][s]) s = (s + 1) % 4;
        ret_valid = 1'b1; ret_id = 2'(id); ret_sub = 2'(s); ret_data = memword(id_k[id], s);
      end
    end
    #1;
    if (d_av) begin
      m = act_k[d_k]; known = 1'b1; er = 1'b0;
      if (!m) er = (nout < NENT);
      else if (sent_k[d_k] != 4'hF) er = d_pf || (nacc_k[d_k] < NSLOT);
      else if (!d_pf && nacc_k[d_k] == NSLOT) er = 1'b0;
      else known = 1'b0;
      if (known) chk(alloc_ready == er, "R4 alloc_ready stall decision", 64'(alloc_ready), 64'(er));
    end
    if (fwd_valid) begin
      int t = int'(fwd_tag);
      chk(live[t], "R7 forward of a load not waiting", 64'(t), 64'(1));
      if (live[t]) begin
        chk(fwd_data == exp_d[t], "R5 R6 forwarded load data", 64'(fwd_data), 64'(exp_d[t]));
        chk(exp_seq[t] > last_seq[exp_kk[t]][exp_sb[t]], "R7 forward order within subblock",
            64'(exp_seq[t]), 64'(last_seq[exp_kk[t]][exp_sb[t]]));
        last_seq[exp_kk[t]][exp_sb[t]] = exp_seq[t];
        if (early[t]) r8_cnt++;
        pend_k[exp_kk[t]]--;
        live[t] = 1'b0;
      end
    end
    if (fill_valid) begin
      k = findk(fill_addr);
      chk(k >= 0 && act_k[k], "R9 fill of a block not pending", 64'(fill_addr), 64'(0));
      if (k >= 0 && act_k[k]) begin
        chk(sent_k[k] == 4'hF && pend_k[k] == 0, "R9 fill before all data and loads done",
            64'({sent_k[k], 8'(pend_k[k])}), 64'({4'hF, 8'h0}));
        chk(int'(fill_sub) == nfill_k[k], "R9 fill subblock order", 64'(fill_sub), 64'(nfill_k[k]));
        chk(fill_data == img[k][fill_sub], "R9 fill data with stores merged", 64'(fill_data), 64'(img[k][fill_sub]));
        chk(fill_pf == pf_k[k], "R10 prefetch flag on fill", 64'(fill_pf), 64'(pf_k[k]));
        nfill_k[k]++;
        if (nfill_k[k] == NSUB) begin
          act_k[k] = 1'b0; nout--; id_busy[rid_k[k]] = 1'b0;
        end
      end
    end
    if (mem_req_valid && mem_req_ready) begin
      k = findk(mem_req_addr);
      chk(k >= 0 && act_k[k] && !reqd_k[k], "R2 R3 one memory request per pending block", 64'(mem_req_addr), 64'(0));
      chk(!id_busy[mem_req_id], "R2 request id of a free entry", 64'(mem_req_id), 64'(0));
      if (k >= 0) begin
        reqd_k[k] = 1'b1; rid_k[k] = int'(mem_req_id);
        id_k[mem_req_id] = k; id_busy[mem_req_id] = 1'b1;
      end
      nreq++;
    end
    if (ret_valid) sent_k[id_k[ret_id]][ret_sub] = 1'b1;
    if (alloc_valid && alloc_ready) begin
      k = d_k;
      if (!act_k[k]) begin
        act_k[k] = 1'b1; reqd_k[k] = 1'b0; sent_k[k] = 4'h0; nacc_k[k] = 0; nfill_k[k] = 0;
        pend_k[k] = 0; pf_k[k] = d_pf; nout++;
        for (int s = 0; s < 4; s++) img[k][s] = memword(k, s);
      end
      if (!d_pf) begin
        pf_k[k] = 1'b0;
        nacc_k[k]++;
        if (d_st) img[k][d_sub] = stmerge(img[k][d_sub], d_wd, d_by, d_sz);
        else begin
          exp_d[tagc] = ldval(img[k][d_sub], d_by, d_sz);
          exp_kk[tagc] = k; exp_sb[tagc] = d_sub; exp_seq[tagc] = seq;
          early[tagc] = sent_k[k][d_sub];
          live[tagc] = 1'b1; pend_k[k]++;
        end
        seq++;
        tagc++;
      end
    end
  endtask

  task automatic set_acc(int k, bit st, int sz, int sub, int by, logic [31:0] wd);
    d_av = 1'b1; d_pf = 1'b0; d_k = k; d_st = st; d_sz = sz; d_sub = sub; d_by = by; d_wd = wd;
  endtask

  task automatic set_pf(int k);
    d_av = 1'b1; d_pf = 1'b1; d_k = k; d_st = 1'b0; d_sz = 0; d_sub = 0; d_by = 0; d_wd = '0;
  endtask

  task automatic drain();
    d_av = 1'b0; ret_en = 1'b1; mem_rdy_en = 1'b1;
    for (int i = 0; i < 3000 && nout > 0; i++) step();
    chk(nout == 0, "R9 every entry retires after its fill", 64'(nout), 64'(0));
  endtask

  initial begin
    void'($urandom(32'd4471));
    for (int k = 0; k < NBLK; k++) begin
      act_k[k] = 0; reqd_k[k] = 0; pf_k[k] = 0; sent_k[k] = 0; nacc_k[k] = 0; nfill_k[k] = 0; pend_k[k] = 0;
      for (int s = 0; s < 4; s++) last_seq[k][s] = -1;
    end
    for (int i = 0; i < NENT; i++) begin id_busy[i] = 0; id_k[i] = 0; end
    for (int t = 0; t < 256; t++) begin live[t] = 0; early[t] = 0; end
    alloc_valid = 0; alloc_pf = 0; alloc_store = 0; alloc_addr = '0; alloc_size = '0; alloc_off = '0;
    alloc_tag = '0; alloc_wdata = '0; mem_req_ready = 0; ret_valid = 0; ret_id = '0; ret_sub = '0; ret_data = '0;
    d_av = 0; d_pf = 0; d_st = 0; d_k = 0; d_sz = 0; d_sub = 0; d_by = 0; d_wd = '0;
    mem_rdy_en = 0; ret_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!mem_req_valid && !fwd_valid && !fill_valid, "R1 outputs idle after reset",
        64'({mem_req_valid, fwd_valid, fill_valid}), 64'(0));

    // R2 R4: fill every entry, hold memory off
    for (int k = 0; k < 4; k++) begin set_acc(k, 0, 2, k, 0, '0); step(); end
    // R3 R6: store then loads join block 0
    set_acc(0, 1, 1, 0, 2, 32'h0000BEEF); step();
    set_acc(0, 0, 1, 0, 2, '0); step();
    set_acc(0, 0, 0, 0, 3, '0); step();
    set_acc(0, 0, 2, 1, 0, '0); step();  // R4: slots exhausted
    set_pf(1); step();                    // R10: prefetch to pending block
    set_acc(4, 0, 2, 0, 0, '0); step();  // R4: no free entry
    d_av = 0; mem_rdy_en = 1;
    repeat (12) step();
    chk(nreq == 4, "R2 R3 one request per claimed entry", 64'(nreq), 64'(4));
    drain();

    // R10: prefetch alone, then prefetch joined by demand
    set_pf(5); step(); drain();
    set_pf(5); step();
    set_acc(5, 0, 1, 3, 2, '0); step();
    drain();

    // R5..R8: random traffic
    mem_rdy_en = 1; ret_en = 1;
    for (int i = 0; i < 5000; i++) begin
      if ($urandom % 10 < 6) begin
        int sz = $urandom % 3;
        int by = ($urandom % 4) & ~((1 << sz) - 1);
        if ($urandom % 12 == 0) set_pf($urandom % NBLK);
        else set_acc($urandom % NBLK, ($urandom % 10 < 3), sz, $urandom % 4, by, $urandom);
      end else d_av = 0;
      step();
    end
    drain();
    begin
      int left = 0;
      for (int t = 0; t < 256; t++) if (live[t]) left++;
      chk(left == 0, "R7 every load forwarded exactly once", 64'(left), 64'(0));
    end
    chk(r8_cnt > 0, "R8 loads to arrived subblocks forwarded", 64'(r8_cnt), 64'(1));
    summary();
  end
endmodule